// File: doc/BRIEF.md
# Four-Source Vectored Interrupt Controller

This block collects interrupt events for a small 4-bit processor core from four sources: a periodic interval-timer tick, external input 0, a serial transfer-complete pulse, and external input 2. Each source owns one request flag and one enable flag. The two external inputs are treated as asynchronous. They pass through a flop synchroniser and then an edge detector. Input 0 takes its active edge from a mode register. Input 2 reacts only to rising edges.

Software reaches the flags through a one-cycle command bus. It can set or clear single request or enable bits, write or read whole nibbles, test-and-clear a request bit, and program the input 0 mode. A request flag set by software is handled exactly like one set by its hardware event. When a flag and its enable are both high, the block drives that source's vectored request line. It also drives a fixed-priority vector index and a wake signal that releases HALT standby. The CPU clears the serviced flag with an acknowledge strobe that carries the vector index.

Top module: `irq_ctl4`

## Requirements
- R1: A synchronous reset (`rst` high) clears all four request flags and all four enable flags, and sets the input 0 mode to rising edge (00). After reset, `vrq`, `irq_any` and `wake` are low.
- R2: A one-cycle pulse on `tmr_tick` sets request bit 0 at the next clock edge. A one-cycle pulse on `ser_done` sets request bit 2 at the next clock edge.
- R3: Input 0 sets request bit 1 according to the mode register: 00 = rising edge, 01 = falling edge, 10 = both edges, 11 = ignored. The flag is visible after the third rising clock edge that follows the pin change, and not after the second.
- R4: Input 2 sets request bit 3 on a rising edge only, with the same three-edge latency. A falling edge leaves the flag clear.
- R5: `vrq[i]` is high exactly when request bit i and enable bit i are both 1. Bus op 3 sets enable bit `bus_sel` and op 4 clears it.
- R6: A request bit set by software has the same effect on `vrq`, `irq_any`, `vec_idx` and `wake` as a hardware event. Op 1 sets bit `bus_sel`, op 2 clears it, and op 6 writes the whole request nibble from `bus_wdata`.
- R7: `irq_ack` high clears request bit `ack_idx` at the next clock edge.
- R8: Op 5 (test-and-clear) returns request bit `bus_sel` in `bus_rdata[0]` during the access and clears that bit at the clock edge.
- R9: `irq_any` is the OR of `vrq`. `vec_idx` gives the lowest-numbered active line, so the order is timer (0), input 0 (1), serial (2), input 2 (3).
- R10: `wake` is high when any of `vrq[2:0]` is high. `vrq[3]` alone never raises `wake`.
- R11: A hardware event in the same cycle as a software clear (op 2, op 5, op 6) or an acknowledge of the same bit leaves the flag set.
- R12: Op 7 writes the enable nibble and op 8 writes the mode from `bus_wdata[1:0]`. Ops 9, 10 and 11 return the request nibble, the enable nibble and the mode on `bus_rdata` during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex0_pin | input | 1 | External input 0, asynchronous |
| ex2_pin | input | 1 | External input 2, asynchronous |
| tmr_tick | input | 1 | Interval timer event pulse |
| ser_done | input | 1 | Serial transfer-complete pulse |
| bus_op | input | 4 | Bus command code (0 = idle) |
| bus_sel | input | 2 | Flag bit selected by bit-level commands |
| bus_wdata | input | 4 | Write data for nibble and mode writes |
| bus_rdata | output | 4 | Read data for the current command |
| irq_ack | input | 1 | Service acknowledge strobe |
| ack_idx | input | 2 | Vector index being acknowledged |
| vrq | output | 4 | Per-source vectored request lines |
| irq_any | output | 1 | Any vectored request pending |
| vec_idx | output | 2 | Highest-priority pending vector |
| wake | output | 1 | HALT release request |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and a wake mask that excludes input 2. With those values it can pin down the three-edge pin latency exactly, and it can show that input 2 alone never wakes the core. Directed scenarios step input 0 through all four edge modes. They also walk the priority encoder down the order by acknowledging vectors one at a time. Finally, they make a hardware event coincide with each kind of software clear and with an acknowledge of the same bit.

// File: rtl/irq_ctl4_pkg.sv
package irq_ctl4_pkg;
  localparam int NSRC  = 4;
  localparam int SRC_W = $clog2(NSRC);
  localparam int SRC_TMR = 0;
  localparam int SRC_EX0 = 1;
  localparam int SRC_SER = 2;
  localparam int SRC_EX2 = 3;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_REQ_SET  = 4'd1,
    OP_REQ_CLR  = 4'd2,
    OP_EN_SET   = 4'd3,
    OP_EN_CLR   = 4'd4,
    OP_TEST_CLR = 4'd5,
    OP_REQ_WR   = 4'd6,
    OP_EN_WR    = 4'd7,
    OP_MODE_WR  = 4'd8,
    OP_REQ_RD   = 4'd9,
    OP_EN_RD    = 4'd10,
    OP_MODE_RD  = 4'd11
  } bus_op_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_OFF  = 2'd3
  } edge_mode_e;

  // Edge qualification of a synchronised level against its previous value.
  function automatic logic edge_hit(input edge_mode_e m, input logic cur, input logic prev);
    case (m)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  // Lowest index among active lines wins.
  function automatic logic [SRC_W-1:0] prio_pick(input logic [NSRC-1:0] v);
    logic [SRC_W-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) idx = SRC_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_ctl4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       hit
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;
  logic                   lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[SYNC_STAGES-1];
    end
  end

  assign lvl = chain[SYNC_STAGES-1];
  assign hit = edge_hit(mode, lvl, prev);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_ctl4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  hw_set,
  input  bus_op_e          op,
  input  logic [SRC_W-1:0] sel,
  input  logic [NSRC-1:0]  wdata,
  input  logic             ack,
  input  logic [SRC_W-1:0] ack_idx,
  output logic [NSRC-1:0]  req_q,
  output logic [NSRC-1:0]  en_q
);
  logic [NSRC-1:0] req_d;
  logic [NSRC-1:0] en_d;

  always_comb begin
    req_d = req_q;
    en_d  = en_q;
    case (op)
      OP_REQ_SET:  req_d[sel] = 1'b1;
      OP_REQ_CLR:  req_d[sel] = 1'b0;
      OP_TEST_CLR: req_d[sel] = 1'b0;
      OP_EN_SET:   en_d[sel]  = 1'b1;
      OP_EN_CLR:   en_d[sel]  = 1'b0;
      OP_REQ_WR:   req_d      = wdata;
      OP_EN_WR:    en_d       = wdata;
      default:     ;
    endcase
    if (ack) req_d[ack_idx] = 1'b0;
    // hardware events take precedence over every clear path
    req_d = req_d | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ctl4_pkg::*;
(
  input  logic [NSRC-1:0]  vrq,
  output logic [SRC_W-1:0] vec_idx,
  output logic             irq_any
);
  assign irq_any = |vrq;
  assign vec_idx = prio_pick(vrq);
endmodule

// File: rtl/irq_ctl4.sv
module irq_ctl4
  import irq_ctl4_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] WAKE_MASK   = 4'b0111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ex0_pin,
  input  logic       ex2_pin,
  input  logic       tmr_tick,
  input  logic       ser_done,
  input  logic [3:0] bus_op,
  input  logic [1:0] bus_sel,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  input  logic       irq_ack,
  input  logic [1:0] ack_idx,
  output logic [3:0] vrq,
  output logic       irq_any,
  output logic [1:0] vec_idx,
  output logic       wake
);
  bus_op_e         op;
  edge_mode_e      mode_q;
  logic            ex0_hit;
  logic            ex2_hit;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] en_q;

  assign op = bus_op_e'(bus_op);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= EDGE_RISE;
    else if (op == OP_MODE_WR) mode_q <= edge_mode_e'(bus_wdata[1:0]);
  end

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ex0 (
    .clk(clk), .rst(rst), .pin(ex0_pin), .mode(mode_q), .hit(ex0_hit)
  );

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ex2 (
    .clk(clk), .rst(rst), .pin(ex2_pin), .mode(EDGE_RISE), .hit(ex2_hit)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[SRC_TMR] = tmr_tick;
    hw_set[SRC_EX0] = ex0_hit;
    hw_set[SRC_SER] = ser_done;
    hw_set[SRC_EX2] = ex2_hit;
  end

  irq_flag_bank u_flags (
    .clk(clk), .rst(rst), .hw_set(hw_set), .op(op), .sel(bus_sel),
    .wdata(bus_wdata), .ack(irq_ack), .ack_idx(ack_idx),
    .req_q(req_q), .en_q(en_q)
  );

  assign vrq  = req_q & en_q;
  assign wake = |(vrq & WAKE_MASK);

  irq_prio_enc u_prio (.vrq(vrq), .vec_idx(vec_idx), .irq_any(irq_any));

  always_comb begin
    case (op)
      OP_TEST_CLR: bus_rdata = {{(NSRC-1){1'b0}}, req_q[bus_sel]};
      OP_REQ_RD:   bus_rdata = req_q;
      OP_EN_RD:    bus_rdata = en_q;
      OP_MODE_RD:  bus_rdata = {{(NSRC-2){1'b0}}, mode_q};
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctl4_chk.sv
module irq_ctl4_chk
  import irq_ctl4_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  hw_set,
  input logic [NSRC-1:0]  req_q,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  vrq,
  input logic             irq_any,
  input logic [SRC_W-1:0] vec_idx,
  input logic             wake,
  input logic [3:0]       bus_op,
  input logic [SRC_W-1:0] bus_sel,
  input logic             irq_ack,
  input logic [SRC_W-1:0] ack_idx
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (req_q == '0 && en_q == '0));

  // R2
  hw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((req_q & $past(hw_set)) == $past(hw_set)));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !hw_set[ack_idx]) |=> !req_q[$past(ack_idx)]);

  // R8
  test_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_op == 4'd5 && !hw_set[bus_sel]) |=> !req_q[$past(bus_sel)]);

  // R9
  vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any |-> vrq[vec_idx]);

  // R9
  vec_prio_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any |-> ((vrq & ((NSRC'(1) << vec_idx) - NSRC'(1))) == '0));

  // R10
  ex2_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (vrq == (NSRC'(1) << SRC_EX2)) |-> !wake);

  // R5
  vrq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((vrq & ~en_q) == '0) && ((vrq & ~req_q) == '0));
endmodule

bind irq_ctl4 irq_ctl4_chk u_chk (
  .clk(clk), .rst(rst), .hw_set(hw_set), .req_q(req_q), .en_q(en_q),
  .vrq(vrq), .irq_any(irq_any), .vec_idx(vec_idx), .wake(wake),
  .bus_op(bus_op), .bus_sel(bus_sel), .irq_ack(irq_ack), .ack_idx(ack_idx)
);

// File: tb/tb_irq_ctl4.sv
module tb_irq_ctl4;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ex0_pin = 1'b0, ex2_pin = 1'b0, tmr_tick = 1'b0, ser_done = 1'b0;
  logic [3:0] bus_op = 4'd0;
  logic [1:0] bus_sel = 2'd0;
  logic [3:0] bus_wdata = 4'd0;
  logic [3:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic [1:0] ack_idx = 2'd0;
  logic [3:0] vrq;
  logic       irq_any;
  logic [1:0] vec_idx;
  logic       wake;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_ctl4 dut (
    .clk(clk), .rst(rst), .ex0_pin(ex0_pin), .ex2_pin(ex2_pin),
    .tmr_tick(tmr_tick), .ser_done(ser_done), .bus_op(bus_op),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .ack_idx(ack_idx), .vrq(vrq), .irq_any(irq_any),
    .vec_idx(vec_idx), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_op(input logic [3:0] op, input logic [1:0] sel, input logic [3:0] wd);
    bus_op = op; bus_sel = sel; bus_wdata = wd;
    step(1);
    bus_op = 4'd0;
  endtask

  task automatic rd(input logic [3:0] op, input logic [1:0] sel, output logic [3:0] val);
    bus_op = op; bus_sel = sel;
    #1 val = bus_rdata;
    step(1);
    bus_op = 4'd0;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    rd(4'd9, 2'd0, v);  chk("R1 req after reset", v, 4'h0);
    rd(4'd10, 2'd0, v); chk("R1 en after reset", v, 4'h0);
    rd(4'd11, 2'd0, v); chk("R1 mode after reset", v, 4'h0);
    chk("R1 outputs idle", {vrq, irq_any, wake}, 6'h0);
  endtask

  task automatic t_pulses();
    logic [3:0] v;
    tmr_tick = 1'b1; step(1); tmr_tick = 1'b0;
    rd(4'd9, 2'd0, v); chk("R2 timer sets bit0", v, 4'h1);
    ser_done = 1'b1; step(1); ser_done = 1'b0;
    rd(4'd9, 2'd0, v); chk("R2 serial sets bit2", v, 4'h5);
    chk("R5 no enable no vrq", vrq, 4'h0);
    do_op(4'd6, 2'd0, 4'h0);
  endtask

  // mode m; edge_first: level driven first; expect set after first/second transition
  task automatic t_ex0_mode(input logic [1:0] m, input logic exp_rise, input logic exp_fall);
    logic [3:0] v;
    do_op(4'd8, 2'd0, {2'b00, m});
    rd(4'd11, 2'd0, v); chk("R12 mode readback", v, {2'b00, m});
    ex0_pin = 1'b1; step(2);
    rd(4'd9, 2'd0, v); chk("R3 ex0 rise not yet", v[1], 1'b0);
    rd(4'd9, 2'd0, v); chk("R3 ex0 rise result", v[1], exp_rise);
    do_op(4'd6, 2'd0, 4'h0);
    ex0_pin = 1'b0; step(2);
    rd(4'd9, 2'd0, v); chk("R3 ex0 fall not yet", v[1], 1'b0);
    rd(4'd9, 2'd0, v); chk("R3 ex0 fall result", v[1], exp_fall);
    do_op(4'd6, 2'd0, 4'h0);
  endtask

  task automatic t_ex2();
    logic [3:0] v;
    ex2_pin = 1'b1; step(2);
    rd(4'd9, 2'd0, v); chk("R4 ex2 rise not yet", v, 4'h0);
    rd(4'd9, 2'd0, v); chk("R4 ex2 rise sets bit3", v, 4'h8);
    do_op(4'd6, 2'd0, 4'h0);
    ex2_pin = 1'b0; step(4);
    rd(4'd9, 2'd0, v); chk("R4 ex2 fall ignored", v, 4'h0);
  endtask

  task automatic t_enable_prio();
    logic [3:0] v;
    do_op(4'd6, 2'd0, 4'hF);
    chk("R5 flags without enable", vrq, 4'h0);
    do_op(4'd3, 2'd0, 4'h0);
    chk("R6 sw flag vrq", vrq, 4'h1);
    chk("R6 sw flag any/idx/wake", {irq_any, vec_idx, wake}, {1'b1, 2'd0, 1'b1});
    do_op(4'd3, 2'd3, 4'h0);
    do_op(4'd4, 2'd0, 4'h0);
    chk("R5 enable set/clear", vrq, 4'h8);
    chk("R10 ex2 alone no wake", {irq_any, vec_idx, wake}, {1'b1, 2'd3, 1'b0});
    do_op(4'd7, 2'd0, 4'hF);
    rd(4'd10, 2'd0, v); chk("R12 enable nibble", v, 4'hF);
    chk("R9 all pending idx0", vec_idx, 2'd0);
    irq_ack = 1'b1; ack_idx = 2'd0; step(1);
    chk("R7 ack clears bit0", vrq, 4'hE);
    chk("R9 next idx1", vec_idx, 2'd1);
    ack_idx = 2'd1; step(1);
    chk("R9 next idx2", {vec_idx, wake}, {2'd2, 1'b1});
    ack_idx = 2'd2; step(1);
    chk("R9 next idx3", {vrq, vec_idx, wake}, {4'h8, 2'd3, 1'b0});
    ack_idx = 2'd3; step(1); irq_ack = 1'b0;
    chk("R9 none pending", {vrq, irq_any}, 5'h0);
  endtask

  task automatic t_test_clr();
    logic [3:0] v;
    do_op(4'd1, 2'd2, 4'h0);
    chk("R6 single bit set", vrq, 4'h4);
    rd(4'd5, 2'd2, v); chk("R8 test returns 1", v, 4'h1);
    chk("R8 cleared", vrq, 4'h0);
    rd(4'd5, 2'd2, v); chk("R8 test returns 0", v, 4'h0);
  endtask

  task automatic t_collide();
    logic [3:0] v;
    do_op(4'd1, 2'd0, 4'h0);
    tmr_tick = 1'b1; bus_op = 4'd2; bus_sel = 2'd0; step(1);
    tmr_tick = 1'b0; bus_op = 4'd0;
    rd(4'd9, 2'd0, v); chk("R11 tick beats clear", v, 4'h1);
    tmr_tick = 1'b1; bus_op = 4'd5; bus_sel = 2'd0; step(1);
    tmr_tick = 1'b0; bus_op = 4'd0;
    rd(4'd9, 2'd0, v); chk("R11 tick beats test-clear", v, 4'h1);
    ser_done = 1'b1; bus_op = 4'd6; bus_wdata = 4'h0; step(1);
    ser_done = 1'b0; bus_op = 4'd0;
    rd(4'd9, 2'd0, v); chk("R11 serial beats nibble write", v, 4'h4);
    ser_done = 1'b1; irq_ack = 1'b1; ack_idx = 2'd2; step(1);
    ser_done = 1'b0; irq_ack = 1'b0;
    rd(4'd9, 2'd0, v); chk("R11 serial beats ack", v, 4'h4);
    do_op(4'd2, 2'd2, 4'h0);
    rd(4'd9, 2'd0, v); chk("R6 bit clear op", v, 4'h0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_pulses();
    t_ex0_mode(2'd0, 1'b1, 1'b0);
    t_ex0_mode(2'd1, 1'b0, 1'b1);
    t_ex0_mode(2'd2, 1'b1, 1'b1);
    t_ex0_mode(2'd3, 1'b0, 1'b0);
    t_ex2();
    t_enable_prio();
    t_test_clr();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule